// File: doc/BRIEF.md
# Recirculating Pattern Field with Programmable Loop Length

This block stores one serial pattern of up to 64 bits and plays it back repeatedly. The bits sit in a cyclic shift register. Every flip-flop stage has its own multiplexer. That multiplexer picks either the next stage up the chain or the bit currently leaving the register. Choosing the feedback at one stage closes a loop of any length from 1 to 64. Because every bit that leaves the output re-enters the loop, the register is both the pattern store and the player, and no separate pattern memory is needed.

During configuration, a serial load mode shifts all 64 stages and fills the register one bit per clock. The first bit loaded ends up in stage 0. During playback, an enable input advances the loop by one bit per clock. A bit counter marks each completed pass through the programmed length. An iteration counter of up to 16384 passes marks the completion of the whole repeated field. A channel sequencer uses these two strobes to decide when to move to the next field.

Top module: `recirc_field`

## Requirements
- R1: An asynchronous active-low reset clears all 64 pattern stages, the bit counter and the iteration counter. While reset holds and just after it, `pat_out`, `pass_done` and `field_done` read 0.
- R2: While `load` is 1, every clock shifts all 64 stages toward stage 0 and takes `load_bit` into stage 63, whatever the values of `enable` and `len_m1`. After 64 load clocks, the first bit loaded is at stage 0 and appears on `pat_out`.
- R3: While `load` is 0 and `enable` is 1, each clock rotates the lowest L = `len_m1`+1 stages by one place. `pat_out` (stage 0) therefore presents bits 0,1,…,L-1 of the loaded pattern and then repeats them cyclically.
- R4: While `load` and `enable` are both 0, `pat_out` and both counters hold, and `pass_done` and `field_done` stay 0.
- R5: During playback, stages L to 63 hold their contents. Widening the length later resumes with those stored bits intact.
- R6: `pass_done` is 1 in the cycle after every enabled shift that completes L shifts since the last pass or since the last load. It is never high otherwise.
- R7: `field_done` is 1 together with every (`rep_m1`+1)-th `pass_done`. This allows up to 16384 passes per field.
- R8: A load clock returns the bit counter and the iteration counter to zero, and no done strobe follows a load clock.
- R9: With `len_m1` = 0 the field is a 1-bit loop. `pat_out` stays constant while enabled, and `pass_done` is high after every enabled shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Serial load mode select |
| load_bit | input | 1 | Serial data taken into stage 63 while loading |
| enable | input | 1 | Advance the loop by one bit when not loading |
| len_m1 | input | 6 | Loop length minus one (0 gives 1 bit, 63 gives 64 bits) |
| rep_m1 | input | 14 | Passes per field minus one |
| pat_out | output | 1 | Pattern bit, stage 0 of the register |
| pass_done | output | 1 | One-cycle strobe after a completed pass |
| field_done | output | 1 | One-cycle strobe after the last pass of the field |

## Verification
On every cycle, the assertions check these properties:
- the output holds and no strobe appears while the field is idle;
- a 1-bit loop keeps its value and strobes each shift;
- a pass strobe only follows an enabled playback shift;
- a field strobe only comes with a pass strobe;
- load clocks never produce strobes.

Only the bench's scenarios can show the following:
- the order in which bits play back for every length from 1 to 64;
- that stages above the loop keep their contents;
- that a reset really clears the stored pattern;
- that the field strobe lands exactly on pass 16384.

// File: rtl/recirc_field_pkg.sv
package recirc_field_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_PLAY = 2'd1,
        MODE_LOAD = 2'd2
    } fld_mode_e;

endpackage

// File: rtl/rf_shift_chain.sv
module rf_shift_chain
    import recirc_field_pkg::*;
#(
    parameter int unsigned BITS  = 64,
    parameter int unsigned LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fld_mode_e        mode,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             ser_in,
    output logic             tap
);

    typedef struct packed {
        logic [BITS-1:0] bits;
    } chain_t;

    chain_t          chain_d, chain_q;
    logic [BITS-1:0] stage_d;

    // Per-stage multiplexer: chain input, feedback from stage 0, or hold.
    for (genvar i = 0; i < BITS; i++) begin : g_stage
        logic upper_in;
        logic loop_in;
        if (i == BITS - 1) begin : g_top
            assign upper_in = ser_in;
            assign loop_in  = chain_q.bits[0];
        end else begin : g_mid
            assign upper_in = chain_q.bits[i+1];
            assign loop_in  = (len_m1 == LEN_W'(i)) ? chain_q.bits[0]
                                                    : chain_q.bits[i+1];
        end
        assign stage_d[i] = (mode == MODE_LOAD) ? upper_in :
                            ((mode == MODE_PLAY) && (LEN_W'(i) <= len_m1)) ? loop_in :
                            chain_q.bits[i];
    end

    always_comb begin
        chain_d      = chain_q;
        chain_d.bits = stage_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign tap = chain_q.bits[0];

endmodule

// File: rtl/rf_pass_counter.sv
module rf_pass_counter
    import recirc_field_pkg::*;
#(
    parameter int unsigned LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fld_mode_e        mode,
    input  logic [LEN_W-1:0] len_m1,
    output logic             wrap
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } pcnt_t;

    pcnt_t pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        wrap = 1'b0;
        unique case (mode)
            MODE_LOAD: pc_d.cnt = '0;
            MODE_PLAY: begin
                // >= guards against a length lowered below the current count
                wrap = (pc_q.cnt >= len_m1);
                pc_d.cnt = wrap ? '0 : pc_q.cnt + 1'b1;
            end
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

endmodule

// File: rtl/rf_iter_counter.sv
module rf_iter_counter
    import recirc_field_pkg::*;
#(
    parameter int unsigned ITER_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fld_mode_e         mode,
    input  logic              wrap,
    input  logic [ITER_W-1:0] rep_m1,
    output logic              last
);

    typedef struct packed {
        logic [ITER_W-1:0] cnt;
    } icnt_t;

    icnt_t ic_d, ic_q;

    always_comb begin
        ic_d = ic_q;
        last = 1'b0;
        if (mode == MODE_LOAD) begin
            ic_d.cnt = '0;
        end else if (wrap) begin
            last     = (ic_q.cnt >= rep_m1);
            ic_d.cnt = last ? '0 : ic_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ic_q <= '0;
        end else begin
            ic_q <= ic_d;
        end
    end

endmodule

// File: rtl/recirc_field.sv
module recirc_field
    import recirc_field_pkg::*;
#(
    parameter int unsigned FIELD_BITS = 64,
    parameter int unsigned ITER_W     = 14,
    localparam int unsigned LEN_W     = $clog2(FIELD_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_bit,
    input  logic              enable,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [ITER_W-1:0] rep_m1,
    output logic              pat_out,
    output logic              pass_done,
    output logic              field_done
);

    typedef struct packed {
        logic pass;
        logic field;
    } strobe_t;

    fld_mode_e mode;
    logic      wrap;
    logic      last;
    strobe_t   st_d, st_q;

    // Load has priority over enable.
    always_comb begin
        if (load) begin
            mode = MODE_LOAD;
        end else if (enable) begin
            mode = MODE_PLAY;
        end else begin
            mode = MODE_IDLE;
        end
    end

    rf_shift_chain #(
        .BITS  (FIELD_BITS),
        .LEN_W (LEN_W)
    ) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .len_m1 (len_m1),
        .ser_in (load_bit),
        .tap    (pat_out)
    );

    rf_pass_counter #(
        .LEN_W (LEN_W)
    ) u_pass (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .len_m1 (len_m1),
        .wrap   (wrap)
    );

    rf_iter_counter #(
        .ITER_W (ITER_W)
    ) u_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .wrap   (wrap),
        .rep_m1 (rep_m1),
        .last   (last)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pass  = wrap;
        st_d.field = last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pass_done  = st_q.pass;
    assign field_done = st_q.field;

endmodule

// File: rtl/recirc_field_chk.sv
module recirc_field_chk #(
    parameter int unsigned LEN_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             enable,
    input logic [LEN_W-1:0] len_m1,
    input logic             pat_out,
    input logic             pass_done,
    input logic             field_done
);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!load && !enable)) |-> ($stable(pat_out) && !pass_done && !field_done));

    assert_pass_after_play_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> ($past(rst_n) && $past(enable && !load)));

    assert_field_with_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        field_done |-> pass_done);

    assert_no_strobe_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (!pass_done && !field_done));

    assert_single_bit_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !load && enable && (len_m1 == '0)) |-> ($stable(pat_out) && pass_done));

endmodule

bind recirc_field recirc_field_chk #(.LEN_W(LEN_W)) u_recirc_field_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .enable     (enable),
    .len_m1     (len_m1),
    .pat_out    (pat_out),
    .pass_done  (pass_done),
    .field_done (field_done)
);

// File: tb/recirc_field_bench.sv
module recirc_field_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        load_bit = 1'b0;
    logic        enable = 1'b0;
    logic [5:0]  len_m1 = '0;
    logic [13:0] rep_m1 = '0;
    logic        pat_out;
    logic        pass_done;
    logic        field_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    recirc_field u_recirc_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_bit   (load_bit),
        .enable     (enable),
        .len_m1     (len_m1),
        .rep_m1     (rep_m1),
        .pat_out    (pat_out),
        .pass_done  (pass_done),
        .field_done (field_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] mkpat(input int s);
        logic [63:0] x;
        x = 64'h9E3779B97F4A7C15 + 64'(s) * 64'hBF58476D1CE4E5B9;
        x = x ^ (x >> 29);
        x = x * 64'h94D049BB133111EB;
        return x ^ (x >> 31);
    endfunction

    // R2: 64 serial clocks, first bit lands in stage 0
    task automatic load_word(input logic [63:0] w);
        load = 1'b1;
        for (int i = 0; i < 64; i++) begin
            load_bit = w[i];
            enable   = i[0];
            @(negedge clk);
        end
        load   = 1'b0;
        enable = 1'b0;
    endtask

    // R3/R6/R7: play n shifts from a fresh load with length L and R passes per field
    task automatic play(input int L, input int R, input logic [63:0] w, input int n);
        for (int t = 0; t < n; t++) begin
            bit ep;
            bit ef;
            ep = (t > 0) && (t % L == 0);
            ef = ep && ((t / L) % R == 0);
            chk(pat_out == w[t % L], "R3 pattern bit", int'(pat_out), int'(w[t % L]));
            chk(pass_done == ep, "R6 pass_done", int'(pass_done), int'(ep));
            chk(field_done == ef, "R7 field_done", int'(field_done), int'(ef));
            enable = 1'b1;
            @(negedge clk);
        end
        enable = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        logic [63:0] model;
        int first_fd;
        int fd_count;

        repeat (3) @(negedge clk);
        chk(pat_out == 1'b0, "R1 pat_out in reset", int'(pat_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pat_out == 1'b0 && pass_done == 1'b0 && field_done == 1'b0,
            "R1 outputs after reset", int'({pat_out, pass_done, field_done}), 0);

        // R1: stored contents cleared, full 64-bit replay is all zero
        len_m1 = 6'd63;
        rep_m1 = 14'd0;
        play(64, 1, 64'd0, 65);

        // R2/R3/R6/R7/R8/R9: sweep every length
        for (int L = 1; L <= 64; L++) begin
            w      = mkpat(L);
            len_m1 = 6'(L - 1);
            rep_m1 = 14'(L % 3);
            load_word(w);
            chk(!pass_done && !field_done, "R8 no strobe after load",
                int'({pass_done, field_done}), 0);
            play(L, (L % 3) + 1, w, 4 * L + 1);
        end

        // R4: idle clocks hold output and produce no strobes
        w      = mkpat(100);
        len_m1 = 6'd7;
        rep_m1 = 14'd0;
        load_word(w);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            chk(pat_out == w[3], "R4 hold pat_out", int'(pat_out), int'(w[3]));
            chk(!pass_done && !field_done, "R4 no strobe", int'({pass_done, field_done}), 0);
            @(negedge clk);
        end
        enable = 1'b1;
        for (int t = 3; t < 8; t++) begin
            chk(pat_out == w[t], "R4 resume order", int'(pat_out), int'(w[t]));
            @(negedge clk);
        end
        chk(pass_done == 1'b1, "R4 pass after resume", int'(pass_done), 1);
        enable = 1'b0;

        // R5: stages above the loop hold while a short loop plays
        w      = mkpat(200);
        len_m1 = 6'd3;
        load_word(w);
        enable = 1'b1;
        repeat (5) @(negedge clk);
        enable = 1'b0;
        model = w;
        for (int i = 0; i < 4; i++) model[i] = w[(i + 5) % 4];
        len_m1 = 6'd63;
        @(negedge clk);
        enable = 1'b1;
        for (int t = 0; t < 64; t++) begin
            chk(pat_out == model[t], "R5 upper stages kept", int'(pat_out), int'(model[t]));
            @(negedge clk);
        end
        enable = 1'b0;

        // R8: load in mid pass restarts counting
        w      = mkpat(300);
        len_m1 = 6'd4;
        rep_m1 = 14'd1;
        load_word(w);
        enable = 1'b1;
        repeat (7) @(negedge clk);
        enable = 1'b0;
        load_word(w);
        chk(!pass_done && !field_done, "R8 strobes after reload", int'({pass_done, field_done}), 0);
        play(5, 2, w, 11);

        // R7: maximum repeat count, field completes exactly at pass 16384
        len_m1   = 6'd0;
        rep_m1   = 14'h3FFF;
        load_word(64'd1);
        first_fd = -1;
        fd_count = 0;
        enable   = 1'b1;
        for (int t = 1; t <= 16385; t++) begin
            @(negedge clk);
            if (field_done) begin
                fd_count++;
                if (first_fd < 0) first_fd = t;
            end
        end
        enable = 1'b0;
        chk(first_fd == 16384, "R7 field_done at pass 16384", first_fd, 16384);
        chk(fd_count == 1, "R7 single field strobe", fd_count, 1);
        chk(pat_out == 1'b1, "R9 one-bit loop constant", int'(pat_out), 1);

        // R1: reset in mid play wipes a full pattern
        len_m1 = 6'd63;
        rep_m1 = 14'd0;
        load_word({64{1'b1}});
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        play(64, 1, 64'd0, 64);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule